// File: doc/BRIEF.md
# Link Self-Test Payload Checker

This block sits on the receive side of a serial link and checks the link during a self-test. Software or a board strap raises a test-enable input. While that input is high and the receiver reports lock, each valid payload word is compared against a locally generated pseudo-random reference. The reference synchronizes itself to the incoming stream: the first valid word after lock loads the generator and is not checked. Every later valid word is checked against the continuation of the sequence.

A status output goes high while the check is running. For each mismatched word it dips low during the second half of one clock cycle, so outside equipment can count the dips and estimate a payload error rate. An 8-bit saturating error counter keeps the test's total. The counter is cleared when a new test starts and can still be read through a small register-read port after the test ends. The block also drives a test/normal data-path select and latches a two-bit clock-source choice for the duration of the test.

Top module: `bist_link_checker`

## Requirements
- R1: While reset is asserted, test_ok_o, path_sel_o, clksrc_o and the error count read through rd_data_o are all 0.
- R2: test_ok_o is high in the cycle after every clock edge that samples test_en_i=1 and lock_i=1, apart from the error dip of R4.
- R3: The reference is PRBS-7 with polynomial x^7+x^6+1. Each new bit is bit6 XOR bit5 of a 7-bit state, which then shifts left with the new bit entering bit0. Words are formed most significant bit first. The first valid word after lock is not checked and loads its 7 least significant bits as the state. Later valid words are compared with the next DATA_W reference bits. Cycles with word_vld_i=0 neither check nor advance the reference.
- R4: A mismatched word sampled at a clock edge makes test_ok_o high in the first (clock-high) half of the following cycle and low in its second (clock-low) half. test_ok_o is high again after the next edge unless another mismatch was sampled there.
- R5: The error count rises by exactly one for each mismatched word and holds at 255 once it reaches 255.
- R6: The error count is cleared at the clock edge that first samples test_en_i=1 after it was 0.
- R7: Reading rd_addr_i = 0x25 returns the error count and any other address returns 0. The count stays readable after test_en_i falls.
- R8: After an edge that samples test_en_i=0, test_ok_o and path_sel_o are 0 and no words are checked. After an edge that samples test_en_i=1, path_sel_o is 1.
- R9: After an edge that samples lock_i=0 during a test, test_ok_o is 0 and mismatches are not counted. The reference loads again from the first valid word after lock returns.
- R10: clksrc_o takes clksrc_sel_i at the edge where a test starts and holds that value while test_en_i stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| test_en_i | input | 1 | Self-test enable |
| lock_i | input | 1 | Receiver lock flag |
| clksrc_sel_i | input | 2 | Clock-source choice for the test |
| word_i | input | DATA_W (16) | Received payload word |
| word_vld_i | input | 1 | word_i holds a new word |
| rd_addr_i | input | 8 | Status register read address |
| test_ok_o | output | 1 | Test status with half-cycle error dips |
| rd_data_o | output | CNT_W (8) | Read data (error count at 0x25) |
| path_sel_o | output | 1 | 1 selects the test data path, 0 the normal path |
| clksrc_o | output | 2 | Clock-source choice latched for the test |

## Verification
The bench sends a continuous reference stream and flips bits in chosen words. It checks the status output in both halves of each cycle. A dip placed in the wrong half, or one that lasts a whole cycle, shows up at once. Invalid cycles carrying corrupted data catch a checker that advances or counts on every cycle. A lock drop while the bench stream keeps running means a design that fails to reload after lock returns reports false errors. A run of 260 errors exposes a counter that wraps back to zero, and restarting the test exposes a count that is not cleared. Reads after the test ends, and reads at a neighbouring address, catch a count that is lost or decoded at the wrong address.

// File: rtl/bist_pkg.sv
`timescale 1ns/1ps
package bist_pkg;
   localparam int unsigned PRBS_ORDER = 7;
   typedef logic [PRBS_ORDER-1:0] prbs_state_t;
endpackage

// File: rtl/bist_prbs_gen.sv
`timescale 1ns/1ps
module bist_prbs_gen
   import bist_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  prbs_state_t        state_i,
   output logic [DATA_W-1:0]  word_o,
   output prbs_state_t        next_o
);
   prbs_state_t stage [DATA_W+1];

   assign stage[0] = state_i;

   for (genvar i = 0; i < DATA_W; i++) begin : g_step
      logic fb;
      assign fb               = stage[i][6] ^ stage[i][5];
      assign word_o[DATA_W-1-i] = fb;
      assign stage[i+1]       = {stage[i][PRBS_ORDER-2:0], fb};
   end

   assign next_o = stage[DATA_W];
endmodule

// File: rtl/bist_err_counter.sv
`timescale 1ns/1ps
module bist_err_counter #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   if (SATURATE) begin : g_sat
      assign step = inc_i && (cnt_q != CNT_MAX);
   end else begin : g_wrap
      assign step = inc_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/bist_status_out.sv
`timescale 1ns/1ps
module bist_status_out #(
   parameter int unsigned    CNT_W     = 8,
   parameter int unsigned    ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h25
) (
   input  logic              clk_i,
   input  logic              ok_i,
   input  logic              err_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic              test_ok_o,
   output logic [CNT_W-1:0]  rd_data_o
);
   // Error dip lands in the clock-low half of the cycle after detection.
   assign test_ok_o = ok_i & ~(err_i & ~clk_i);

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == STAT_ADDR) begin
         rd_data_o = cnt_i;
      end
   end
endmodule

// File: rtl/bist_link_checker.sv
`timescale 1ns/1ps
module bist_link_checker
   import bist_pkg::*;
#(
   parameter int unsigned       DATA_W    = 16,
   parameter int unsigned       CNT_W     = 8,
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       SEL_W     = 2,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h25,
   parameter bit                SATURATE  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              test_en_i,
   input  logic              lock_i,
   input  logic [SEL_W-1:0]  clksrc_sel_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              word_vld_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic              test_ok_o,
   output logic [CNT_W-1:0]  rd_data_o,
   output logic              path_sel_o,
   output logic [SEL_W-1:0]  clksrc_o
);
   if (DATA_W < PRBS_ORDER) begin : g_bad_width
      $error("DATA_W must be at least the PRBS order");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W out of range");
   end

   logic              en_q;
   logic              ok_q;
   logic              err_q;
   logic              seeded_q;
   prbs_state_t       state_q;
   logic [SEL_W-1:0]  src_q;
   logic [DATA_W-1:0] exp_word;
   prbs_state_t       exp_next;
   logic [CNT_W-1:0]  cnt_q;
   logic              active;
   logic              en_rise;
   logic              mismatch;

   assign active   = test_en_i & lock_i;
   assign en_rise  = test_en_i & ~en_q;
   assign mismatch = active & word_vld_i & seeded_q & (word_i != exp_word);

   bist_prbs_gen #(.DATA_W(DATA_W)) u_prbs (
      .state_i (state_q),
      .word_o  (exp_word),
      .next_o  (exp_next)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q     <= 1'b0;
         ok_q     <= 1'b0;
         err_q    <= 1'b0;
         seeded_q <= 1'b0;
         state_q  <= '0;
         src_q    <= '0;
      end else begin
         en_q  <= test_en_i;
         ok_q  <= active;
         err_q <= mismatch;
         if (en_rise) begin
            src_q <= clksrc_sel_i;
         end
         if (!active) begin
            seeded_q <= 1'b0;
         end else if (word_vld_i) begin
            seeded_q <= 1'b1;
            state_q  <= seeded_q ? exp_next : word_i[PRBS_ORDER-1:0];
         end
      end
   end

   bist_err_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (en_rise),
      .inc_i  (mismatch),
      .cnt_o  (cnt_q)
   );

   bist_status_out #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_stat (
      .clk_i     (clk_i),
      .ok_i      (ok_q),
      .err_i     (err_q),
      .cnt_i     (cnt_q),
      .rd_addr_i (rd_addr_i),
      .test_ok_o (test_ok_o),
      .rd_data_o (rd_data_o)
   );

   assign path_sel_o = en_q;
   assign clksrc_o   = src_q;
endmodule

// File: rtl/bist_link_checker_sva.sv
`timescale 1ns/1ps
module bist_link_checker_sva #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SEL_W = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             test_en_i,
   input logic             lock_i,
   input logic             ok_q,
   input logic             err_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             path_sel_o,
   input logic [SEL_W-1:0] clksrc_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   a_r2_ok_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (test_en_i && lock_i) |=> ok_q);

   a_r8_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !test_en_i |=> (!ok_q && !path_sel_o));

   a_r4_dip_only_when_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |-> ok_q);

   a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_MAX && test_en_i && path_sel_o) |=> (cnt_q == CNT_MAX));

   a_r9_no_count_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lock_i && test_en_i && path_sel_o) |=> $stable(cnt_q));

   a_r10_source_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (test_en_i && path_sel_o) |=> $stable(clksrc_o));
endmodule

bind bist_link_checker bist_link_checker_sva #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_sva (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .test_en_i  (test_en_i),
   .lock_i     (lock_i),
   .ok_q       (ok_q),
   .err_q      (err_q),
   .cnt_q      (cnt_q),
   .path_sel_o (path_sel_o),
   .clksrc_o   (clksrc_o)
);

// File: tb/test_bist_link_checker.sv
`timescale 1ns/1ps
module test_bist_link_checker;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic         lock = 1'b0;
   logic [1:0]   sel = 2'b00;
   logic [W-1:0] word = '0;
   logic         vld = 1'b0;
   logic [7:0]   addr = 8'h25;
   logic         ok;
   logic [7:0]   rdata;
   logic         path;
   logic [1:0]   src;

   int n_chk = 0;
   int n_bad = 0;
   logic [6:0] gen = 7'h7F;
   logic hi_s, lo_s, path_s;
   logic [7:0] cnt_s;

   always #10 clk = ~clk;

   bist_link_checker i_bist_link_checker (
      .clk_i(clk), .rst_ni(rst_n), .test_en_i(en), .lock_i(lock),
      .clksrc_sel_i(sel), .word_i(word), .word_vld_i(vld), .rd_addr_i(addr),
      .test_ok_o(ok), .rd_data_o(rdata), .path_sel_o(path), .clksrc_o(src));

   // fields: en lock vld flip exp_hi exp_lo exp_path | exp_cnt
   localparam logic [14:0] VEC [16] = '{
      {7'b1000001, 8'd0},  // enable, no lock (R6 clear)
      {7'b1100111, 8'd0},  // lock acquired (R2)
      {7'b1110111, 8'd0},  // seed word (R3)
      {7'b1110111, 8'd0},  // good word
      {7'b1111101, 8'd1},  // error dip (R4)
      {7'b1110111, 8'd1},
      {7'b1101111, 8'd1},  // invalid, corrupted: ignored (R3)
      {7'b1111101, 8'd2},
      {7'b1111101, 8'd3},  // back-to-back errors
      {7'b1011001, 8'd3},  // unlocked: not counted (R9)
      {7'b1100111, 8'd3},
      {7'b1110111, 8'd3},  // reseed after lock (R9)
      {7'b1110111, 8'd3},
      {7'b1111101, 8'd4},
      {7'b0111000, 8'd4},  // disabled: no check (R8)
      {7'b0000000, 8'd4}
   };

   task automatic chk(input bit good, input string tag, input int act, input int exp);
      n_chk++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] next_word();
      logic [W-1:0] w;
      for (int i = W-1; i >= 0; i--) begin
         logic b;
         b = gen[6] ^ gen[5];
         w[i] = b;
         gen = {gen[5:0], b};
      end
      return w;
   endfunction

   task automatic drive(input logic e, input logic l, input logic v, input logic f);
      en = e; lock = l; vld = v;
      if (v) word = next_word() ^ {{(W-1){1'b0}}, f};
      else   word = 16'hDEAD;
   endtask

   // called in the clock-low phase; samples both halves of the next cycle
   task automatic tick();
      @(posedge clk);
      #5;
      hi_s = ok; path_s = path; cnt_s = rdata;
      #10;
      lo_s = ok;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #5;
      chk(ok == 1'b0, "R1 status", ok, 0);
      chk(path == 1'b0, "R1 path", path, 0);
      chk(rdata == 8'd0, "R1 count", rdata, 0);
      chk(src == 2'd0, "R1 source", src, 0);
      #10;
      rst_n = 1'b1;
      sel = 2'b10;

      for (int k = 0; k < 16; k++) begin
         logic [14:0] v;
         v = VEC[k];
         drive(v[14], v[13], v[12], v[11]);
         tick();
         if (k == 0) sel = 2'b01;
         chk(hi_s == v[10], $sformatf("R2 row %0d first half", k), hi_s, v[10]);
         chk(lo_s == v[9], $sformatf("R4 row %0d second half", k), lo_s, v[9]);
         chk(path_s == v[8], $sformatf("R8 row %0d path", k), path_s, v[8]);
         chk(cnt_s == v[7:0], $sformatf("R5 row %0d count", k), cnt_s, v[7:0]);
      end

      // R10: captured at start, held through the test
      chk(src == 2'b10, "R10 held source", src, 2);

      // R7: address decode, count retained after test end
      addr = 8'h24; #1;
      chk(rdata == 8'd0, "R7 other address", rdata, 0);
      addr = 8'h25; #1;
      chk(rdata == 8'd4, "R7 retained count", rdata, 4);

      // R6: new test clears count; R10 captures new source
      sel = 2'b11;
      drive(1'b1, 1'b0, 1'b0, 1'b0);
      tick();
      chk(cnt_s == 8'd0, "R6 cleared on restart", cnt_s, 0);
      chk(src == 2'b11, "R10 new source", src, 3);

      // R5: saturation at 255
      drive(1'b1, 1'b1, 1'b1, 1'b0);
      tick();
      for (int k = 0; k < 255; k++) begin
         drive(1'b1, 1'b1, 1'b1, 1'b1);
         tick();
      end
      chk(cnt_s == 8'd255, "R5 reaches 255", cnt_s, 255);
      for (int k = 0; k < 5; k++) begin
         drive(1'b1, 1'b1, 1'b1, 1'b1);
         tick();
      end
      chk(cnt_s == 8'd255, "R5 saturates", cnt_s, 255);
      chk(lo_s == 1'b0, "R4 dip while saturated", lo_s, 0);
      chk(hi_s == 1'b1, "R4 first half high", hi_s, 1);

      // R8: end of test
      drive(1'b0, 1'b1, 1'b1, 1'b1);
      tick();
      chk(hi_s == 1'b0 && lo_s == 1'b0, "R8 status low after end", hi_s, 0);
      chk(path_s == 1'b0, "R8 normal path", path_s, 0);
      chk(cnt_s == 8'd255, "R7 count kept after end", cnt_s, 255);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule